// File: doc/BRIEF.md
# SPI Command GPIO Expander

This block is a SPI slave that turns short host command frames into levels on nine output-only pins. The host lowers chip-select, shifts an opcode byte in, and may follow it with one data byte. Pins 0 to 7 are written together from the data byte that follows the bank-load opcode. Pin 8 has no place in that byte and is driven by its own pair of single-byte opcodes.

The pin state is held in registers and driven on the output ports until the next valid command or reset. The SPI inputs are brought into the system clock through flop synchronisers, and serial clock edges are detected in that domain. Opcodes that belong to a sibling NAND path, and any other unrecognised opcode, leave the pins alone. There is no readback, no input direction and no interrupt.

Top module: `spi_pin_expander`

## Requirements
- R1: While reset is asserted, and after it is released with no command yet received, all nine outputs are low.
- R2: The serial link is SPI mode 0: data is taken on the rising serial clock edge, most significant bit first, and a byte is complete after eight rising edges with chip-select low.
- R3: Opcode 0x09 followed by a data byte in the same frame sets output bit n (n = 0..7) to data bit n; pin 8 is unchanged.
- R4: Single-byte opcode 0x0C drives pin 8 low and opcode 0x0D drives pin 8 high (opcode bit 0 is the level); pins 0 to 7 are unchanged.
- R5: Every opcode other than 0x09, 0x0C and 0x0D, including the NAND opcodes 0x08, 0x0A and 0x0B and their trailing bytes, leaves all nine outputs unchanged.
- R6: Only the first command of a frame acts; bytes after its completion (after the opcode for 0x0C/0x0D, after the data byte for 0x09) are ignored until chip-select rises.
- R7: If chip-select rises before a byte is complete, the partial byte is discarded, the outputs keep their values, and the next frame starts counting bits afresh.
- R8: Opcode 0x09 with chip-select raised before any data byte completes changes no output.
- R9: Outputs change at most once per completed byte and never while chip-select has been high for three or more system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock from the host (idles low) |
| cs_n | input | 1 | SPI chip-select, active low |
| mosi | input | 1 | SPI serial data from the host |
| gpio_out | output | 9 | Output pin levels, bit n drives pin n |

## Verification
The hardest state to reach from the ports is a frame cut short: chip-select rising after some but not all bits of an opcode or data byte, followed by a clean frame that must not inherit the stale bit count. The bench builds these by driving the serial lines bit by bit from a task that can stop after any number of bits, then immediately sends a full command and checks that only the full command lands. Around that, every data byte value is swept through the bank load and every opcode value is swept with pin 8 pre-set to the opposite of the level the opcode would drive, so a wrongly decoded opcode always shows.

// File: rtl/spi_pin_expander.sv
module spi_pin_expander #(
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] OP_LOAD_BANK = 8'h09,
  parameter logic [6:0] OP_PIN8_PAIR = 7'h06
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  output logic [8:0] gpio_out
);
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [1:0] {WAIT_OP, WAIT_DATA, DONE} fsm_t;

  logic [SYNC_STAGES-1:0] sck_q, cs_q, mo_q;
  logic                   sck_d;
  logic [BYTE_W-2:0]      shreg;
  logic [CNT_W-1:0]       bit_cnt;
  fsm_t                   st;
  logic [BYTE_W-1:0]      bank_q;
  logic                   pin8_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0;
      cs_q  <= '1;
      mo_q  <= '0;
      sck_d <= 1'b0;
    end else begin
      sck_q <= {sck_q[SYNC_STAGES-2:0], sclk};
      cs_q  <= {cs_q[SYNC_STAGES-2:0], cs_n};
      mo_q  <= {mo_q[SYNC_STAGES-2:0], mosi};
      sck_d <= sck_q[SYNC_STAGES-1];
    end

  wire              cs_idle  = cs_q[SYNC_STAGES-1];
  wire              rise     = sck_q[SYNC_STAGES-1] & ~sck_d & ~cs_idle;
  wire [BYTE_W-1:0] byte_in  = {shreg, mo_q[SYNC_STAGES-1]};
  wire              byte_end = rise && (bit_cnt == CNT_W'(BYTE_W - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
      st      <= WAIT_OP;
      bank_q  <= '0;
      pin8_q  <= 1'b0;
    end else if (cs_idle) begin
      bit_cnt <= '0;
      st      <= WAIT_OP;
    end else if (rise) begin
      shreg   <= byte_in[BYTE_W-2:0];
      bit_cnt <= bit_cnt + 1'b1;
      if (byte_end)
        case (st)
          WAIT_OP: begin
            if (byte_in == OP_LOAD_BANK) st <= WAIT_DATA;
            else begin
              st <= DONE;
              if (byte_in[BYTE_W-1:1] == OP_PIN8_PAIR) pin8_q <= byte_in[0];
            end
          end
          WAIT_DATA: begin
            bank_q <= byte_in;
            st     <= DONE;
          end
          default: st <= DONE;
        endcase
    end

  assign gpio_out = {pin8_q, bank_q};
endmodule

// File: rtl/spi_pin_expander_chk.sv
module spi_pin_expander_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic [8:0] gpio_out
);
  // R1
  reset_low_chk: assert property (@(posedge clk) !rst_n |-> gpio_out == 9'd0);

  // R4
  pin8_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gpio_out[8]) |-> $stable(gpio_out[7:0]));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> $stable(gpio_out));

  // R9
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gpio_out) |=> $stable(gpio_out));
endmodule

bind spi_pin_expander spi_pin_expander_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .gpio_out(gpio_out)
);

// File: tb/spi_pin_expander_tb.sv
`timescale 1ns/1ps
module spi_pin_expander_tb;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic [8:0] gpio_out;
  logic [8:0] exp_q;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  spi_pin_expander u_dut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
                          .mosi(mosi), .gpio_out(gpio_out));

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic [8:0] exp);
    checks++;
    if (gpio_out !== exp) begin
      errors++;
      $display("FAIL %s actual=%03h expected=%03h", tag, gpio_out, exp);
    end
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      mosi = b[i];
      wclk(3);
      sclk = 1'b1;
      wclk(3);
      sclk = 1'b0;
    end
  endtask

  task automatic frame_start();
    cs_n = 1'b0;
    wclk(3);
  endtask

  task automatic frame_end();
    wclk(3);
    cs_n = 1'b1;
    wclk(8);
  endtask

  task automatic cmd1(logic [7:0] op);
    frame_start(); send_bits(op, 8); frame_end();
  endtask

  task automatic cmd2(logic [7:0] op, logic [7:0] d);
    frame_start(); send_bits(op, 8); send_bits(d, 8); frame_end();
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wclk(3);
    check("R1 in reset", 9'h000);
    rst_n = 1'b1;
    wclk(6);
    check("R1 after reset", 9'h000);
    exp_q = 9'h000;

    // R3 / R2: sweep all data bytes through the bank load
    for (int d = 0; d < 256; d++) begin
      cmd2(8'h09, 8'(d));
      exp_q[7:0] = 8'(d);
      check("R3 bank load", exp_q);
    end

    // R4 / R5: sweep all opcodes, pin 8 preset opposite to opcode bit 0
    for (int op = 0; op < 256; op++) begin
      logic [7:0] o;
      o = 8'(op);
      cmd1(o[0] ? 8'h0C : 8'h0D);
      exp_q[8] = ~o[0];
      if (o == 8'h09) continue;
      cmd1(o);
      if (o == 8'h0C || o == 8'h0D) begin
        exp_q[8] = o[0];
        check("R4 pin8 opcode", exp_q);
      end else
        check("R5 other opcode", exp_q);
    end

    cmd2(8'h09, 8'h5A); exp_q[7:0] = 8'h5A;
    cmd1(8'h0C); exp_q[8] = 1'b0;
    check("R3 setup", exp_q);

    // R5: NAND opcodes with trailing bytes
    cmd2(8'h08, 8'hFF); check("R5 nand write", exp_q);
    cmd2(8'h0A, 8'h00); check("R5 nand read", exp_q);
    cmd2(8'h0B, 8'h0D); check("R5 nand fast", exp_q);

    // R6: extra bytes after the first command
    frame_start(); send_bits(8'h0D, 8); send_bits(8'h09, 8); send_bits(8'h00, 8); frame_end();
    exp_q[8] = 1'b1;
    check("R6 trailing after pin8", exp_q);
    frame_start(); send_bits(8'h09, 8); send_bits(8'h3C, 8); send_bits(8'hFF, 8); frame_end();
    exp_q[7:0] = 8'h3C;
    check("R6 trailing after load", exp_q);

    // R8: load opcode with no data
    cmd1(8'h09); check("R8 load without data", exp_q);

    // R7: partial bytes
    for (int n = 1; n < 8; n++) begin
      frame_start(); send_bits(8'h0C, n); frame_end();
      check("R7 partial opcode", exp_q);
      frame_start(); send_bits(8'h09, 8); send_bits(8'hC3, n); frame_end();
      check("R7 partial data", exp_q);
    end
    frame_start(); send_bits(8'hFF, 5); frame_end();
    cmd2(8'h09, 8'h81); exp_q[7:0] = 8'h81;
    check("R7 fresh count after cut", exp_q);
    frame_start(); send_bits(8'h0D, 3); frame_end();
    cmd1(8'h0C); exp_q[8] = 1'b0;
    check("R7 fresh opcode after cut", exp_q);

    // R2: MSB-first, bit n to pin n
    cmd2(8'h09, 8'h01); exp_q[7:0] = 8'h01;
    check("R2 lsb pattern", exp_q);
    cmd2(8'h09, 8'h80); exp_q[7:0] = 8'h80;
    check("R2 msb pattern", exp_q);

    // R1: reset mid-state
    rst_n = 1'b0;
    wclk(2);
    check("R1 re-reset", 9'h000);
    rst_n = 1'b1;
    wclk(4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule